// File: doc/BRIEF.md
# Wrapping-Burst Memory Responder

This block sits on the slave side of a synchronous external memory bus and answers read accesses from a small internal array. A master starts an access with a one-cycle request strobe that carries a byte address and a burst flag. After a programmable number of wait cycles, the block drives one data beat with a transfer acknowledge on each clock. During a burst, only the word index inside the current line advances, and it wraps back to the start of that line. The part of the address above the line never changes.

The port can be 32 or 16 bits wide, and the line can be 4 or 8 words long. On a 16-bit port the halfword select takes part in the count, so each word needs two beats. By default the master sets the burst length through a burst-continue input, which is sampled on every acknowledged beat. A configuration input can instead tell the block to ignore that input and always return exactly one full line. A request without the burst flag is a single-beat access: it returns one datum and the block goes back to idle.

Top module: `burst_wrap_slave`

## Requirements
- R1: After reset, and after a reset applied in the middle of a burst, `ack` and `busy` read 0.
- R2: A request is accepted only on an edge where `busy` is 0. A `req_valid` pulse while `busy` is 1 does not change the beats of the running access, and it does not start a new access afterwards.
- R3: The block accepts a request at clock edge E. It then holds `ack` low for exactly `cfg_wait` cycles after E, so the first acknowledged beat is cycle `cfg_wait`+1. All later beats of the same access follow on consecutive cycles.
- R4: A burst on a 32-bit port clears address bits 2 and 1 of the start address. It then returns words whose in-line index (address bits 4:2) runs up by one modulo 8, while the word index above bit 4 stays fixed.
- R5: With `cfg_len4`=1, the word index runs modulo 4 inside the aligned 4-word group that holds the start word, and address bit 4 stays fixed.
- R6: On a 16-bit port the halfword select (address bit 1) is the lowest bit of the count. Halfword 0 is data bits 31:16 and halfword 1 is bits 15:0. The half appears on `rdata[15:0]`, with `rdata[31:16]`=0.
- R7: With `cfg_fixed_len`=0, a beat acknowledged while `bdip` is 1 is followed by another beat. A beat acknowledged while `bdip` is 0 is the last beat. A burst never returns more than one line: 4 or 8 words, and twice that number of beats on a 16-bit port.
- R8: With `cfg_fixed_len`=1, a burst ignores `bdip` and returns exactly one full line of beats.
- R9: A single-beat access (`req_burst`=0) returns exactly one acknowledged beat, whatever `bdip` is. The beat comes from the addressed word, and on a 16-bit port from the half chosen by address bit 1. `busy` is 0 in the cycle that follows the beat.
- R10: The word at index i (address bits ADDR_W-1:2) holds {16'hC0DE ^ i, 16'h1000 + i}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request strobe, sampled when idle |
| req_burst | input | 1 | 1 = wrapping burst, 0 = single beat |
| req_addr | input | ADDR_W | Byte address of the access |
| bdip | input | 1 | Burst-continue indication from the master |
| cfg_port16 | input | 1 | 1 = 16-bit port, 0 = 32-bit port |
| cfg_len4 | input | 1 | 1 = 4-word line, 0 = 8-word line |
| cfg_fixed_len | input | 1 | 1 = ignore `bdip`, return a full line |
| cfg_wait | input | WAIT_W | Wait cycles before the first beat |
| ack | output | 1 | Transfer acknowledge, one per data beat |
| rdata | output | 32 | Beat data, zero when `ack` is low |
| busy | output | 1 | An access is in progress |

## Verification
Several properties are checked on every cycle. Beats run back to back until the last one. A beat taken with `bdip` low ends the burst. A single beat returns the block to idle. The beat counter never passes one line. The line base never moves during a burst. With a 4-word line, address bit 4 stays fixed, and on a 32-bit port the halfword bit stays fixed. Only the bench scenarios can show that the order of returned data is right for each port width, line length and start offset. The same holds for the exact wait latency, the termination point set by `bdip`, the limit at one full line, and whether a request made while busy is dropped.

// File: rtl/burst_wrap_pkg.sv
// Shared types and the fill rule of the read-only line store.
// Assumes 32-bit storage words; index width is set by the users.
package burst_wrap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DATA = 2'd2
    } seq_state_t;

    // Content of the storage word at a given index.
    function automatic logic [31:0] fill_word(input int unsigned idx);
        logic [15:0] i16;
        i16 = idx[15:0];
        return {16'hC0DE ^ i16, 16'h1000 + i16};
    endfunction

endpackage

// File: rtl/line_store.sv
// Read-only word array with a combinational read port.
// Assumes the array is small; content comes from the package fill rule.
module line_store #(
    parameter int IDX_W = 6
) (
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_word
);
    import burst_wrap_pkg::*;

    localparam int DEPTH = 1 << IDX_W;

    logic [31:0] words [DEPTH];

    // Fill every entry from the package rule.
    for (genvar g = 0; g < DEPTH; g++) begin : g_fill
        assign words[g] = fill_word(g);
    end

    // Look up the addressed word.
    assign rd_word = words[rd_idx];

endmodule

// File: rtl/wrap_addr_gen.sv
// Holds the line base and the in-line pointer {word index[2:0], halfword}.
// On advance it steps only the in-line bits and wraps at the 4- or 8-word line.
// Assumes port16/len4 are stable during an access (latched by the sequencer).
module wrap_addr_gen #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              load_burst,
    input  logic              load_port16,
    input  logic              port16,
    input  logic              len4,
    input  logic              advance,
    output logic [ADDR_W-3:0] word_idx,
    output logic              half_sel
);
    localparam int BASE_W = ADDR_W - 5;

    logic [BASE_W-1:0] base;
    logic [3:0]        ptr;
    logic [3:0]        step;
    logic [3:0]        wrap_mask;
    logic [3:0]        ptr_next;

    // Increment size and wrap field for the current port and line length.
    always_comb begin
        step      = port16 ? 4'd1 : 4'd2;
        wrap_mask = len4 ? 4'b0111 : 4'b1111;
        ptr_next  = (ptr & ~wrap_mask) | ((ptr + step) & wrap_mask);
    end

    // Capture the start address, or step the in-line pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base <= '0;
            ptr  <= '0;
        end else if (load) begin
            base <= load_addr[ADDR_W-1:5];
            if (load_burst)
                ptr <= {load_addr[4:3], 2'b00};
            else
                ptr <= {load_addr[4:2], load_port16 & load_addr[1]};
        end else if (advance) begin
            ptr <= ptr_next;
        end
    end

    assign word_idx = {base, ptr[3:1]};
    assign half_sel = ptr[0];

    // R4
    base_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        advance && !load |=> $stable(base));
    // R5
    quad_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        advance && !load && len4 |=> ptr[3] == $past(ptr[3]));
    // R6
    word_port_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        advance && !load && !port16 |=> ptr[0] == $past(ptr[0]));

endmodule

// File: rtl/beat_sequencer.sv
// Access state machine: accepts a request when idle, counts wait cycles,
// then acknowledges one beat per cycle until the burst-continue handshake,
// the fixed line length, or the single-beat rule ends the access.
// Assumes cfg inputs are sampled only when a request is accepted.
module beat_sequencer #(
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_burst,
    input  logic              cfg_port16,
    input  logic              cfg_len4,
    input  logic              cfg_fixed_len,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic              bdip,
    output logic              load,
    output logic              advance,
    output logic              ack,
    output logic              busy,
    output logic              port16_q,
    output logic              len4_q
);
    import burst_wrap_pkg::*;

    localparam int CNT_W = 5;

    seq_state_t        state;
    logic [WAIT_W-1:0] wcnt;
    logic [CNT_W-1:0]  beat_cnt;
    logic [CNT_W-1:0]  line_beats;
    logic              burst_q;
    logic              fixed_q;
    logic              last;

    // Beats in one line and whether the current beat ends the access.
    always_comb begin
        line_beats = len4_q ? CNT_W'(4) : CNT_W'(8);
        if (port16_q)
            line_beats = line_beats << 1;
        last = !burst_q
             || (beat_cnt == line_beats - CNT_W'(1))
             || (!fixed_q && !bdip);
    end

    assign ack     = (state == ST_DATA);
    assign busy    = (state != ST_IDLE);
    assign load    = (state == ST_IDLE) && req_valid;
    assign advance = ack && !last;

    // Sequence idle -> wait -> data beats -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            wcnt     <= '0;
            beat_cnt <= '0;
            burst_q  <= 1'b0;
            fixed_q  <= 1'b0;
            port16_q <= 1'b0;
            len4_q   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        burst_q  <= req_burst;
                        fixed_q  <= cfg_fixed_len;
                        port16_q <= cfg_port16;
                        len4_q   <= cfg_len4;
                        wcnt     <= cfg_wait;
                        beat_cnt <= '0;
                        state    <= (cfg_wait == '0) ? ST_DATA : ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    wcnt <= wcnt - WAIT_W'(1);
                    if (wcnt == WAIT_W'(1))
                        state <= ST_DATA;
                end
                ST_DATA: begin
                    if (last)
                        state <= ST_IDLE;
                    else
                        beat_cnt <= beat_cnt + CNT_W'(1);
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3
    beat_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack && !last |=> ack);
    // R3
    wait_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load && cfg_wait != '0 |=> !ack);
    // R7
    bdip_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack && burst_q && !fixed_q && !bdip |=> !ack);
    // R7
    line_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> beat_cnt < line_beats);
    // R9
    single_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack && !burst_q |=> !busy);
    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(burst_q) && $stable(fixed_q) && $stable(port16_q));

endmodule

// File: rtl/burst_wrap_slave.sv
// Top level of the wrapping-burst memory responder: sequencer, address
// generator and word store, plus the port-width data steering.
// Assumes ADDR_W > 5 so that at least one line-base bit exists.
module burst_wrap_slave #(
    parameter int ADDR_W = 8,
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_burst,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              bdip,
    input  logic              cfg_port16,
    input  logic              cfg_len4,
    input  logic              cfg_fixed_len,
    input  logic [WAIT_W-1:0] cfg_wait,
    output logic              ack,
    output logic [31:0]       rdata,
    output logic              busy
);
    localparam int IDX_W = ADDR_W - 2;

    logic             load;
    logic             advance;
    logic             port16_q;
    logic             len4_q;
    logic [IDX_W-1:0] word_idx;
    logic             half_sel;
    logic [31:0]      word;

    beat_sequencer #(.WAIT_W(WAIT_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_burst     (req_burst),
        .cfg_port16    (cfg_port16),
        .cfg_len4      (cfg_len4),
        .cfg_fixed_len (cfg_fixed_len),
        .cfg_wait      (cfg_wait),
        .bdip          (bdip),
        .load          (load),
        .advance       (advance),
        .ack           (ack),
        .busy          (busy),
        .port16_q      (port16_q),
        .len4_q        (len4_q)
    );

    wrap_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .load_addr   (req_addr),
        .load_burst  (req_burst),
        .load_port16 (cfg_port16),
        .port16      (port16_q),
        .len4        (len4_q),
        .advance     (advance),
        .word_idx    (word_idx),
        .half_sel    (half_sel)
    );

    line_store #(.IDX_W(IDX_W)) u_store (
        .rd_idx  (word_idx),
        .rd_word (word)
    );

    // Steer the word or the selected half onto the data output.
    always_comb begin
        if (!ack)
            rdata = '0;
        else if (port16_q)
            rdata = {16'h0000, half_sel ? word[15:0] : word[31:16]};
        else
            rdata = word;
    end

    // R6
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack && port16_q |-> rdata[31:16] == 16'h0000);

endmodule

// File: tb/burst_wrap_slave_test.sv
module burst_wrap_slave_test;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 8;
    localparam int WAIT_W = 3;
    localparam int NVEC = 10;

    // {burst, port16, len4, fixed, poke, wait[2:0], addr[7:0], n[7:0]}
    localparam logic [23:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'h2C, 8'd8},
        {1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'd2, 8'h18, 8'd3},
        {1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 3'd1, 8'h48, 8'd3},
        {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 8'h64, 8'd5},
        {1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 3'd3, 8'hF8, 8'd1},
        {1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd1, 8'h8C, 8'd4},
        {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 8'h0E, 8'd2},
        {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'h00, 8'd12},
        {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 3'd4, 8'h30, 8'd1},
        {1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 8'h1C, 8'd0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_burst = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              bdip = 1'b0;
    logic              cfg_port16 = 1'b0;
    logic              cfg_len4 = 1'b0;
    logic              cfg_fixed_len = 1'b0;
    logic [WAIT_W-1:0] cfg_wait = '0;
    logic              ack;
    logic [31:0]       rdata;
    logic              busy;

    int tests = 0;
    int fails = 0;

    burst_wrap_slave #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_burst(req_burst),
        .req_addr(req_addr), .bdip(bdip), .cfg_port16(cfg_port16),
        .cfg_len4(cfg_len4), .cfg_fixed_len(cfg_fixed_len), .cfg_wait(cfg_wait),
        .ack(ack), .rdata(rdata), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R10 storage rule
    function automatic logic [31:0] mem_word(input int i);
        logic [15:0] v;
        v = 16'(i);
        return {16'hC0DE ^ v, 16'h1000 + v};
    endfunction

    // Expected data of beat k (R4, R5, R6, R9).
    function automatic logic [31:0] exp_beat(input logic burst, input logic p16,
            input logic len4, input logic [7:0] addr, input int k);
        int a, lw, grp, off, h, w;
        logic [31:0] d;
        a = int'(addr) >> 2;
        if (!burst) begin
            d = mem_word(a);
            if (!p16) return d;
            return {16'h0, addr[1] ? d[15:0] : d[31:16]};
        end
        lw  = len4 ? 4 : 8;
        a   = a & ~1;
        grp = a & ~(lw - 1);
        off = a - grp;
        if (!p16) return mem_word(grp + ((off + k) % lw));
        h = (2 * off + k) % (2 * lw);
        w = grp + h / 2;
        d = mem_word(w);
        return {16'h0, (h % 2) ? d[15:0] : d[31:16]};
    endfunction

    task automatic run_vec(input logic [23:0] v);
        logic burst, p16, len4, fixed, poke;
        int wt, n, exp_n, lb, k, first;
        logic done;
        {burst, p16, len4, fixed, poke} = v[23:19];
        wt = int'(v[18:16]);
        n  = int'(v[7:0]);
        lb = (len4 ? 4 : 8) * (p16 ? 2 : 1);
        if (!burst) exp_n = 1;
        else if (fixed) exp_n = lb;
        else exp_n = (n < lb) ? n : lb;
        @(negedge clk);
        req_valid = 1'b1; req_burst = burst; req_addr = v[15:8];
        cfg_port16 = p16; cfg_len4 = len4; cfg_fixed_len = fixed;
        cfg_wait = WAIT_W'(wt); bdip = (n > 1);
        k = 0; first = 0; done = 1'b0;
        for (int c = 1; c <= wt + 40 && !done; c++) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (poke && c == wt + 1) begin
                req_valid = 1'b1; req_burst = 1'b1; req_addr = 8'hA4;
            end
            if (ack) begin
                if (k == 0) begin
                    first = c;
                    check("R3 first-beat latency", 32'(c), 32'(wt + 1));
                end else begin
                    check("R3 consecutive beat", 32'(c), 32'(first + k));
                end
                check("R4/R5/R6/R9 beat data", rdata, exp_beat(burst, p16, len4, v[15:8], k));
                k++;
                bdip = (k < n);
            end else if (k > 0) begin
                done = 1'b1;
            end
        end
        req_valid = 1'b0;
        check("R7/R8/R9 beat count", 32'(k), 32'(exp_n));
        check("R9 idle after access", {31'b0, busy}, 32'd0);
        @(negedge clk);
        check("R2 no late accept", {30'b0, busy, ack}, 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset ack/busy", {30'b0, ack, busy}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {30'b0, ack, busy}, 32'd0);

        for (int i = 0; i < NVEC; i++)
            run_vec(VEC[i]);

        // R1 reset in the middle of a burst
        @(negedge clk);
        req_valid = 1'b1; req_burst = 1'b1; req_addr = 8'h40;
        cfg_port16 = 1'b0; cfg_len4 = 1'b0; cfg_fixed_len = 1'b0;
        cfg_wait = '0; bdip = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R1 burst running", {31'b0, ack}, 32'd1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-burst reset", {30'b0, ack, busy}, 32'd0);
        rst_n = 1'b1;
        bdip = 1'b0;
        @(negedge clk);
        check("R1 stays idle", {30'b0, ack, busy}, 32'd0);

        // A vector after the reset still works (R4)
        run_vec({1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 8'hEC, 8'd4});

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule